// File: doc/BRIEF.md
# System-Bus to Peripheral-Bus Bridge

This block sits between a pipelined high-performance system bus (AHB-style) and a simple two-phase peripheral bus (APB-style). It is a slave on the system side. It is the sole master on the peripheral side. Each system-bus beat that selects the bridge has its address and direction latched. The following cycle supplies the write data. The bridge then runs one SETUP cycle and one ENABLE cycle on the peripheral bus.

A second-level decode of a fixed slot field in the latched address picks one of N peripheral select lines. An address in the bridge region whose slot has no peripheral still takes the two peripheral cycles, with no select raised. The system side is stalled during SETUP. Ready is raised again in the ENABLE cycle, and read data from the selected peripheral is passed back in that cycle. A new request taken at the end of ENABLE goes straight into the next SETUP. Peripherals have no wait-state or error signalling, so every access takes exactly two peripheral cycles.

Top module: `sysbus_periph_bridge`

## Requirements
- R1: While reset is held and after it is released with no request, every `psel` bit and `penable` are low, `hreadyout` is high and `hresp` is low.
- R2: No request is taken unless `hsel`, `hready` and `htrans[1]` are all high. The htrans codes are IDLE=0, BUSY=1, NONSEQ=2, SEQ=3. A cycle with BUSY, with IDLE, or with `hsel` low leaves the next cycle with no select, `penable` low and `hreadyout` high.
- R3: In the cycle after a request is taken (SETUP), `penable` and `hreadyout` are low. `paddr` equals the taken `haddr` and `pwrite` equals the taken `hwrite`. `pwdata` equals the `hwdata` driven in that cycle.
- R4: SETUP is always followed by exactly one ENABLE cycle. In ENABLE, `penable` is high and `psel`, `paddr`, `pwrite` and `pwdata` hold their SETUP values.
- R5: `hreadyout` is high during ENABLE. If a new request is taken at the end of ENABLE, the next cycle is SETUP. Otherwise the bus goes idle, with `psel` all low and `penable` low.
- R6: The slot field is `haddr[15:12]`. Slot value i below N_PERIPH (4) raises only `psel[i]` in SETUP and ENABLE. Slot values 4 to 15 raise no select but still take the SETUP and ENABLE cycles.
- R7: During the ENABLE cycle of a read, `hrdata` equals `prdata[i*32 +: 32]` of the selected peripheral i. For an unmatched slot, `hrdata` is zero.
- R8: `hresp` is always low (OKAY).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Synchronous reset, active low |
| hsel | input | 1 | Bridge region selected by the system decoder |
| haddr | input | 32 | System-bus address |
| htrans | input | 2 | Transfer type (IDLE/BUSY/NONSEQ/SEQ) |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready seen by all slaves |
| hreadyout | output | 1 | Bridge ready; low stalls the master |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data returned to the master |
| paddr | output | 32 | Peripheral address |
| psel | output | 4 | One-hot peripheral selects |
| penable | output | 1 | High in the second peripheral cycle |
| pwrite | output | 1 | Peripheral direction |
| pwdata | output | 32 | Peripheral write data |
| prdata | input | 128 | Read data of all peripherals, peripheral i at bits i*32 +: 32 |

## Verification
Requests are sent in three ways. Isolated beats with idle gaps cover the ENABLE-to-IDLE path. Chained beats, where the next address is offered during ENABLE, cover the direct ENABLE-to-SETUP path. A beat that arrives during a gap is distinguished from one that arrives in a chain only by the state the bus passes through. Beats that use NONSEQ and SEQ show that both codes are taken. Cycles that present BUSY, IDLE or a deselected bridge show that only real requests start a transfer. Slot values both inside and outside the populated range separate correct one-hot decoding and read steering from the zero-select path.

// File: rtl/bridge_pkg.sv
// Shared definitions for the system-to-peripheral bridge.
// Assumes the standard 2-bit transfer-type encoding on the system side.
package bridge_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ENABLE = 2'd2
    } apb_phase_e;

    localparam logic [1:0] HT_IDLE   = 2'd0;
    localparam logic [1:0] HT_BUSY   = 2'd1;
    localparam logic [1:0] HT_NONSEQ = 2'd2;
    localparam logic [1:0] HT_SEQ    = 2'd3;

endpackage

// File: rtl/ahb_req_capture.sv
// Holds the address, direction and write data of the current request.
// Assumes address/direction arrive with the accept pulse and write data
// one cycle later, while load_wdata is high.
module ahb_req_capture #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic              load_wdata,
    input  logic [DATA_W-1:0] hwdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Latch address and direction at the end of an accepted address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= haddr;
            write_q <= hwrite;
        end
    end

    // Latch write data at the end of the SETUP cycle, so that it is held through ENABLE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (load_wdata) begin
            wdata_q <= hwdata;
        end
    end

endmodule

// File: rtl/apb_phase_fsm.sv
// Peripheral-bus sequencer: IDLE -> SETUP -> ENABLE -> (SETUP | IDLE).
// Assumes no wait states: SETUP and ENABLE each last exactly one cycle.
module apb_phase_fsm
    import bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    output apb_phase_e phase,
    output logic       in_setup,
    output logic       in_enable
);

    apb_phase_e phase_nxt;

    // Choose the next phase from the current phase and a newly taken request.
    always_comb begin
        unique case (phase)
            PH_IDLE:   phase_nxt = accept ? PH_SETUP : PH_IDLE;
            PH_SETUP:  phase_nxt = PH_ENABLE;
            PH_ENABLE: phase_nxt = accept ? PH_SETUP : PH_IDLE;
            default:   phase_nxt = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end

    assign in_setup  = (phase == PH_SETUP);
    assign in_enable = (phase == PH_ENABLE);

endmodule

// File: rtl/apb_slot_decoder.sv
// Second-level decode: turns the slot field of the latched address into
// one-hot peripheral selects. Slots without a peripheral give all zeros.
module apb_slot_decoder #(
    parameter int N_PERIPH = 4,
    parameter int SLOT_W   = 4
) (
    input  logic [SLOT_W-1:0]   slot,
    output logic [N_PERIPH-1:0] sel_vec
);

    // One comparator per populated slot.
    for (genvar gi = 0; gi < N_PERIPH; gi++) begin : g_slot
        assign sel_vec[gi] = (slot == SLOT_W'(gi));
    end

endmodule

// File: rtl/apb_read_mux.sv
// Steers the read data of the selected peripheral; zero when none is selected.
// Assumes sel_vec is one-hot or zero.
module apb_read_mux #(
    parameter int N_PERIPH = 4,
    parameter int DATA_W   = 32
) (
    input  logic [N_PERIPH-1:0]        sel_vec,
    input  logic [N_PERIPH*DATA_W-1:0] prdata,
    output logic [DATA_W-1:0]          rdata
);

    // AND-OR mux over all peripherals.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_PERIPH; i++) begin
            if (sel_vec[i]) rdata = rdata | prdata[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/sysbus_periph_bridge.sv
// System-bus slave / peripheral-bus master bridge.
// Assumes the system decoder drives hsel for the whole bridge region, and that
// hready is the bus-wide ready, which includes this block's hreadyout.
// Every peripheral access is one SETUP plus one ENABLE cycle; no wait states.
module sysbus_periph_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int N_PERIPH    = 4,
    parameter int SLOT_LSB    = 12,
    parameter int REGION_BITS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hsel,
    input  logic [ADDR_W-1:0]          haddr,
    input  logic [1:0]                 htrans,
    input  logic                       hwrite,
    input  logic [DATA_W-1:0]          hwdata,
    input  logic                       hready,
    output logic                       hreadyout,
    output logic                       hresp,
    output logic [DATA_W-1:0]          hrdata,
    output logic [ADDR_W-1:0]          paddr,
    output logic [N_PERIPH-1:0]        psel,
    output logic                       penable,
    output logic                       pwrite,
    output logic [DATA_W-1:0]          pwdata,
    input  logic [N_PERIPH*DATA_W-1:0] prdata
);

    localparam int SLOT_W = REGION_BITS - SLOT_LSB;

    apb_phase_e            phase;
    logic                  in_setup;
    logic                  in_enable;
    logic                  accept;
    logic [ADDR_W-1:0]     addr_q;
    logic                  write_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [N_PERIPH-1:0]   sel_vec;
    logic [DATA_W-1:0]     rd_sel;

    // A real request on a ready bus, taken only when no SETUP is in progress.
    assign accept = hsel && hready && htrans[1] && !in_setup;

    ahb_req_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .haddr      (haddr),
        .hwrite     (hwrite),
        .load_wdata (in_setup),
        .hwdata     (hwdata),
        .addr_q     (addr_q),
        .write_q    (write_q),
        .wdata_q    (wdata_q)
    );

    apb_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .phase     (phase),
        .in_setup  (in_setup),
        .in_enable (in_enable)
    );

    apb_slot_decoder #(
        .N_PERIPH (N_PERIPH),
        .SLOT_W   (SLOT_W)
    ) u_decode (
        .slot    (addr_q[SLOT_LSB +: SLOT_W]),
        .sel_vec (sel_vec)
    );

    apb_read_mux #(
        .N_PERIPH (N_PERIPH),
        .DATA_W   (DATA_W)
    ) u_rmux (
        .sel_vec (sel_vec),
        .prdata  (prdata),
        .rdata   (rd_sel)
    );

    // Peripheral-side outputs: selects only during an active access.
    always_comb begin
        psel    = (phase != PH_IDLE) ? sel_vec : '0;
        penable = in_enable;
        paddr   = addr_q;
        pwrite  = write_q;
        pwdata  = in_setup ? hwdata : wdata_q;
    end

    // System-side outputs: stall only in SETUP; return read data in ENABLE.
    always_comb begin
        hreadyout = !in_setup;
        hresp     = 1'b0;
        hrdata    = (in_enable && !write_q) ? rd_sel : '0;
    end

endmodule

// File: rtl/sysbus_periph_bridge_chk.sv
// Protocol checker for the bridge, bound to every instance of the top module.
module sysbus_periph_bridge_chk #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int N_PERIPH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hsel,
    input logic [1:0]          htrans,
    input logic                hready,
    input logic                hreadyout,
    input logic [ADDR_W-1:0]   paddr,
    input logic [N_PERIPH-1:0] psel,
    input logic                penable,
    input logic                pwrite,
    input logic [DATA_W-1:0]   pwdata
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(psel)); // R6

    AST_SETUP_THEN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (psel != '0 && !penable) |=> (penable && $stable(psel) && $stable(paddr)
                                      && $stable(pwrite) && $stable(pwdata))); // R4

    AST_STALL_THEN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |=> penable); // R4

    AST_ENABLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        penable |=> !penable); // R5

    AST_READY_IN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> hreadyout); // R5

    AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hready && htrans[1] && hreadyout) |=> (!hreadyout && !penable)); // R3

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hreadyout && !(hsel && htrans[1])) |=> (hreadyout && !penable && psel == '0)); // R2

endmodule

bind sysbus_periph_bridge sysbus_periph_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N_PERIPH (N_PERIPH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsel      (hsel),
    .htrans    (htrans),
    .hready    (hready),
    .hreadyout (hreadyout),
    .paddr     (paddr),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .pwdata    (pwdata)
);

// File: tb/test_sysbus_periph_bridge.sv
`timescale 1ns/1ps
module test_sysbus_periph_bridge;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsel = 1'b0;
    logic [31:0]   haddr = '0;
    logic [1:0]    htrans = 2'd0;
    logic          hwrite = 1'b0;
    logic [31:0]   hwdata = '0;
    logic          hready;
    logic          hreadyout;
    logic          hresp;
    logic [31:0]   hrdata;
    logic [31:0]   paddr;
    logic [NP-1:0] psel;
    logic          penable;
    logic          pwrite;
    logic [31:0]   pwdata;
    logic [NP*32-1:0] prdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign hready = hreadyout;

    // Peripheral model: value depends on index and address.
    function automatic logic [31:0] periph_val(input int idx, input logic [31:0] a);
        return {8'(idx) + 8'h10, a[23:0]} ^ 32'h0055_AA00;
    endfunction

    always_comb begin
        for (int i = 0; i < NP; i++) prdata[i*32 +: 32] = periph_val(i, paddr);
    end

    function automatic logic [NP-1:0] exp_sel(input logic [31:0] a);
        int s = int'(a[15:12]);
        return (s < NP) ? NP'(1 << s) : '0;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] a);
        int s = int'(a[15:12]);
        return (s < NP) ? periph_val(s, a) : 32'h0;
    endfunction

    bit watchdog_fired = 1'b0;

    sysbus_periph_bridge i_sysbus_periph_bridge (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .hreadyout(hreadyout),
        .hresp(hresp), .hrdata(hrdata), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "psel idle", 64'(psel), 64'h0);
        chk(req, "penable idle", 64'(penable), 64'h0);
        chk(req, "hreadyout idle", 64'(hreadyout), 64'h1);
        chk("R8", "hresp", 64'(hresp), 64'h0);
    endtask

    // Called at a negedge with hreadyout high; returns at the ENABLE negedge.
    task automatic xfer(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                        input logic [1:0] ttype);
        logic [NP-1:0] s_sel;
        logic [31:0]   s_pw;
        hsel = 1'b1; haddr = a; hwrite = wr; htrans = ttype;
        @(negedge clk);
        hsel = $urandom_range(0, 1) != 0; htrans = 2'd0;
        haddr = $urandom; hwrite = $urandom_range(0, 1) != 0;
        hwdata = wd;
        #0.5;
        // SETUP
        chk("R3", "setup penable", 64'(penable), 64'h0);
        chk("R3", "setup hreadyout", 64'(hreadyout), 64'h0);
        chk("R3", "setup paddr", 64'(paddr), 64'(a));
        chk("R3", "setup pwrite", 64'(pwrite), 64'(wr));
        chk("R6", "setup psel", 64'(psel), 64'(exp_sel(a)));
        if (wr) chk("R3", "setup pwdata", 64'(pwdata), 64'(wd));
        s_sel = psel; s_pw = pwdata;
        @(negedge clk);
        // ENABLE
        chk("R4", "enable penable", 64'(penable), 64'h1);
        chk("R4", "enable psel held", 64'(psel), 64'(s_sel));
        chk("R4", "enable paddr held", 64'(paddr), 64'(a));
        chk("R4", "enable pwrite held", 64'(pwrite), 64'(wr));
        if (wr) chk("R4", "enable pwdata held", 64'(pwdata), 64'(s_pw));
        chk("R5", "enable hreadyout", 64'(hreadyout), 64'h1);
        chk("R8", "hresp", 64'(hresp), 64'h0);
        if (!wr) chk("R7", "enable hrdata", 64'(hrdata), 64'(exp_rd(a)));
    endtask

    task automatic gap();
        hsel = 1'b0; htrans = 2'd0;
        @(negedge clk);
        chk_idle("R5");
    endtask

    task automatic ignored(input logic s, input logic [1:0] t);
        hsel = s; htrans = t; haddr = 32'h4000_1000; hwrite = 1'b1;
        @(negedge clk);
        chk_idle("R2");
        hsel = 1'b0; htrans = 2'd0;
    endtask

    function automatic logic [31:0] rand_addr();
        return {16'h4000, 4'($urandom_range(0, 15)), 10'($urandom), 2'b00};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // R2: non-requests are ignored
        ignored(1'b1, 2'd1);
        ignored(1'b1, 2'd0);
        ignored(1'b0, 2'd2);

        // Directed: isolated write, read, unmatched slots (R6, R7)
        xfer(32'h4000_0010, 1'b1, 32'hDEAD_BEEF, 2'd2); gap();
        xfer(32'h4000_3024, 1'b0, 32'h0, 2'd2);          gap();
        xfer(32'h4000_9000, 1'b0, 32'h0, 2'd2);          gap();
        xfer(32'h4000_F004, 1'b1, 32'h1234_5678, 2'd3);  gap();
        // Back-to-back chain ENABLE -> SETUP (R5), SEQ accepted (R2)
        xfer(32'h4000_1008, 1'b1, 32'hA5A5_0001, 2'd2);
        xfer(32'h4000_2008, 1'b0, 32'h0, 2'd3);
        xfer(32'h4000_2008, 1'b1, 32'h0F0F_F0F0, 2'd3);
        gap();

        // Random mix
        for (int k = 0; k < 80; k++) begin
            xfer(rand_addr(), $urandom_range(0, 1) != 0, $urandom,
                 ($urandom_range(0, 1) != 0) ? 2'd2 : 2'd3);
            if ($urandom_range(0, 2) == 0) gap();
        end
        gap();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            watchdog_fired = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog all actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule